// File: doc/BRIEF.md
# Cartridge Program Bank Mapper

This block sits between an 8-bit console CPU and the program memories of a cartridge. For every CPU access it decides whether the address lands in program ROM, in work RAM or in nothing at all. It also gives the 8K physical bank number and the offset inside that bank. The 0x8000–0xFFFF area is cut into four 8K slots. A two-bit slicing mode chooses whether those slots behave as one 32K window, two 16K windows, one 16K window plus two 8K windows, or four separate 8K windows. Each of the three lower slots can be switched between ROM and RAM. The 0x6000–0x7FFF window always shows one 8K RAM bank, and a base register chooses which one.

Software programs the mapper through byte writes to a small register set in the 0x51xx range. RAM writes are gated by a two-register unlock key. A write enable is raised only when that key is correct and the addressed slot currently holds RAM. The ROM and RAM arrays, bus timing and every other cartridge feature live outside this block.

Top module: `pbm_prg_mapper`

## Requirements
- R1: Reset forces the mode register to 3 (four 8K windows), both key registers and the RAM base to 0, and the four bank registers to 0xFC, 0xFD, 0xFE and 0xFF, all flagged ROM. Straight after reset, 0x8000, 0xA000, 0xC000 and 0xE000 therefore read ROM banks 0x7C, 0x7D, 0x7E and 0x7F, and no RAM write is enabled.
- R2: A write to bank register n (address 0x5114+n) stores data bits 6:0 as the bank number. Data bit 7 equal to 0 maps the slot to RAM and equal to 1 maps it to ROM, except that register 3 always maps ROM.
- R3: In mode 0, all four slots are ROM. The 8K bank for slot s (s = address bits 14:13) is {reg3[6:2], s}, and the RAM flags are ignored.
- R4: In mode 1, slots 0–1 use {reg1[6:1], s[0]} and slots 2–3 use {reg3[6:1], s[0]}, the upper half always ROM. When reg1 selects RAM, the two RAM banks are that value masked to 3 bits.
- R5: In mode 2, slots 0–1 follow the mode 1 rule for reg1, slot 2 uses reg2 directly with reg2's RAM flag, and slot 3 uses reg3 directly as ROM.
- R6: In mode 3, slot s uses register s directly. Any bank number selected as RAM is reduced to its low 3 bits.
- R7: ram_we is 1 only when key register A (0x5102) holds 0x02 and key register B (0x5103) holds 0x01. Any other pair blocks every RAM write.
- R8: ram_we is also 1 only for an enabled CPU write to an address whose current mapping is RAM. A write to a ROM slot, including the 0xE000 slot, never raises it.
- R9: Addresses 0x6000–0x7FFF select RAM bank equal to the RAM base register (0x5113, data bits 2:0). map_offset is always address bits 12:0.
- R10: map_sel encodes 0 = none (open bus), 1 = ROM, 2 = RAM. Addresses below 0x6000, and any RAM bank at or above RAM_BANKS (default 4), give none with bank 0 and no write enable.
- R11: Register writes take effect only with cpu_en and cpu_wr both high, at exactly 0x5100 (mode, data bits 1:0), 0x5102, 0x5103, 0x5113 and 0x5114–0x5117. Writes to other addresses leave every register unchanged. A register write is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_en | input | 1 | CPU access valid this cycle |
| cpu_wr | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| map_sel | output | 2 | 0 none, 1 ROM, 2 RAM |
| map_bank | output | BANK_W (7) | Physical 8K bank number |
| map_offset | output | 13 | Offset inside the 8K bank |
| ram_we | output | 1 | RAM write enable |

## Verification
Every slicing mode is driven with a register set that mixes RAM-flagged and ROM-flagged bank values. This separates the shift applied in each mode, the slot-to-register assignment, and whether a mode honours or ignores the RAM flag. RAM bank numbers with high bits set, and ones that land past the fitted RAM, show the 3-bit mask and the open-bus result. The key registers are cycled through correct, swapped and partly correct pairs while RAM writes are attempted. Writes to neighbouring non-register addresses, and writes with cpu_en low, confirm that the decode is exact.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam int NSLOT = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ROM  = 2'd1,
    SEL_RAM  = 2'd2
  } map_sel_e;

  typedef enum logic [1:0] {
    MODE_32K   = 2'd0,
    MODE_16K   = 2'd1,
    MODE_16K8K = 2'd2,
    MODE_8K    = 2'd3
  } slice_mode_e;

  localparam logic [15:0] A_MODE    = 16'h5100;
  localparam logic [15:0] A_KEY_A   = 16'h5102;
  localparam logic [15:0] A_KEY_B   = 16'h5103;
  localparam logic [15:0] A_RAMBASE = 16'h5113;
  localparam logic [15:0] A_BANK0   = 16'h5114;

  localparam logic [7:0] KEY_A_VAL = 8'h02;
  localparam logic [7:0] KEY_B_VAL = 8'h01;

endpackage

// File: rtl/pbm_rst_sync.sv
module pbm_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/pbm_regfile.sv
module pbm_regfile
  import pbm_pkg::*;
#(
  parameter int          BANK_W     = 7,
  parameter int          RAM_SEL_W  = 3,
  parameter logic [1:0]  RESET_MODE = 2'd3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [15:0]                     addr,
  input  logic [7:0]                      wdata,
  output logic [1:0]                      mode_q,
  output logic [7:0]                      key_a_q,
  output logic [7:0]                      key_b_q,
  output logic [RAM_SEL_W-1:0]            ram_base_q,
  output logic [NSLOT-1:0][BANK_W-1:0]    bank_num_q,
  output logic [NSLOT-2:0]                bank_ram_q
);

  logic [1:0]           mode_d;
  logic [7:0]           key_a_d;
  logic [7:0]           key_b_d;
  logic [RAM_SEL_W-1:0] ram_base_d;

  // Next-state for the control registers.
  always_comb begin
    mode_d     = mode_q;
    key_a_d    = key_a_q;
    key_b_d    = key_b_q;
    ram_base_d = ram_base_q;
    if (wr_en) begin
      if (addr == A_MODE)    mode_d     = wdata[1:0];
      if (addr == A_KEY_A)   key_a_d    = wdata;
      if (addr == A_KEY_B)   key_b_d    = wdata;
      if (addr == A_RAMBASE) ram_base_d = wdata[RAM_SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= RESET_MODE;
      key_a_q    <= '0;
      key_b_q    <= '0;
      ram_base_q <= '0;
    end else begin
      mode_q     <= mode_d;
      key_a_q    <= key_a_d;
      key_b_q    <= key_b_d;
      ram_base_q <= ram_base_d;
    end
  end

  // One bank register per slot; the last slot carries no RAM flag.
  for (genvar i = 0; i < NSLOT; i++) begin : g_bank
    localparam logic [BANK_W-1:0] RST_NUM = BANK_W'(8'hFC + i);

    logic              hit;
    logic [BANK_W-1:0] num_d;
    logic [BANK_W-1:0] num_q;

    assign hit = wr_en && (addr == A_BANK0 + 16'(i));

    always_comb begin
      num_d = num_q;
      if (hit) num_d = BANK_W'(wdata[6:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) num_q <= RST_NUM;
      else        num_q <= num_d;
    end

    assign bank_num_q[i] = num_q;

    if (i < NSLOT - 1) begin : g_flag
      logic ram_d;
      logic ram_q;

      always_comb begin
        ram_d = ram_q;
        if (hit) ram_d = ~wdata[7];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ram_q <= 1'b0;
        else        ram_q <= ram_d;
      end

      assign bank_ram_q[i] = ram_q;
    end
  end

endmodule

// File: rtl/pbm_slot_decode.sv
module pbm_slot_decode
  import pbm_pkg::*;
#(
  parameter int BANK_W    = 7,
  parameter int RAM_SEL_W = 3
) (
  input  logic [1:0]                   slot_i,
  input  logic [1:0]                   mode_i,
  input  logic [NSLOT-1:0][BANK_W-1:0] bank_num_i,
  input  logic [NSLOT-2:0]             bank_ram_i,
  output logic                         is_ram_o,
  output logic [BANK_W-1:0]            bank_o
);

  logic [BANK_W-1:0] num;
  logic              ram;
  logic              slot_flag;

  // RAM flag of the slot's own register (mode 3); the last slot has none.
  always_comb begin
    unique case (slot_i)
      2'd0:    slot_flag = bank_ram_i[0];
      2'd1:    slot_flag = bank_ram_i[1];
      2'd2:    slot_flag = bank_ram_i[2];
      default: slot_flag = 1'b0;
    endcase
  end

  always_comb begin
    num = bank_num_i[3];
    ram = 1'b0;
    unique case (mode_i)
      MODE_32K: begin
        num = {bank_num_i[3][BANK_W-1:2], slot_i};
      end
      MODE_16K: begin
        if (!slot_i[1]) begin
          num = {bank_num_i[1][BANK_W-1:1], slot_i[0]};
          ram = bank_ram_i[1];
        end else begin
          num = {bank_num_i[3][BANK_W-1:1], slot_i[0]};
        end
      end
      MODE_16K8K: begin
        if (!slot_i[1]) begin
          num = {bank_num_i[1][BANK_W-1:1], slot_i[0]};
          ram = bank_ram_i[1];
        end else if (!slot_i[0]) begin
          num = bank_num_i[2];
          ram = bank_ram_i[2];
        end else begin
          num = bank_num_i[3];
        end
      end
      default: begin
        num = bank_num_i[slot_i];
        ram = slot_flag;
      end
    endcase
  end

  assign is_ram_o = ram;
  assign bank_o   = ram ? BANK_W'(num[RAM_SEL_W-1:0]) : num;

endmodule

// File: rtl/pbm_wgate.sv
module pbm_wgate
  import pbm_pkg::*;
(
  input  logic       cpu_en,
  input  logic       cpu_wr,
  input  logic [1:0] sel_i,
  input  logic [7:0] key_a_i,
  input  logic [7:0] key_b_i,
  output logic       ram_we_o
);

  logic unlocked;

  assign unlocked = (key_a_i == KEY_A_VAL) && (key_b_i == KEY_B_VAL);
  assign ram_we_o = cpu_en && cpu_wr && (sel_i == SEL_RAM) && unlocked;

endmodule

// File: rtl/pbm_prg_mapper.sv
module pbm_prg_mapper
  import pbm_pkg::*;
#(
  parameter int         BANK_W     = 7,
  parameter int         RAM_SEL_W  = 3,
  parameter int         RAM_BANKS  = 4,
  parameter logic [1:0] RESET_MODE = 2'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_en,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [1:0]        map_sel,
  output logic [BANK_W-1:0] map_bank,
  output logic [12:0]       map_offset,
  output logic              ram_we
);

  localparam logic [BANK_W:0]    RAM_LIMIT_B = (BANK_W+1)'(RAM_BANKS);
  localparam logic [RAM_SEL_W:0] RAM_LIMIT_S = (RAM_SEL_W+1)'(RAM_BANKS);

  logic                         rst_sync_n;
  logic                         reg_wr;
  logic [1:0]                   mode_q;
  logic [7:0]                   key_a_q;
  logic [7:0]                   key_b_q;
  logic [RAM_SEL_W-1:0]         ram_base_q;
  logic [NSLOT-1:0][BANK_W-1:0] bank_num_q;
  logic [NSLOT-2:0]             bank_ram_q;
  logic                         dec_ram;
  logic [BANK_W-1:0]            dec_bank;
  map_sel_e                     sel_c;
  logic [BANK_W-1:0]            bank_c;

  assign reg_wr = cpu_en && cpu_wr;

  pbm_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  pbm_regfile #(
    .BANK_W     (BANK_W),
    .RAM_SEL_W  (RAM_SEL_W),
    .RESET_MODE (RESET_MODE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr),
    .addr       (cpu_addr),
    .wdata      (cpu_wdata),
    .mode_q     (mode_q),
    .key_a_q    (key_a_q),
    .key_b_q    (key_b_q),
    .ram_base_q (ram_base_q),
    .bank_num_q (bank_num_q),
    .bank_ram_q (bank_ram_q)
  );

  pbm_slot_decode #(
    .BANK_W    (BANK_W),
    .RAM_SEL_W (RAM_SEL_W)
  ) u_dec (
    .slot_i     (cpu_addr[14:13]),
    .mode_i     (mode_q),
    .bank_num_i (bank_num_q),
    .bank_ram_i (bank_ram_q),
    .is_ram_o   (dec_ram),
    .bank_o     (dec_bank)
  );

  // Area select: upper 32K through the slot decoder, 0x6000 window from
  // the base register, everything else open bus.
  always_comb begin
    sel_c  = SEL_NONE;
    bank_c = '0;
    if (cpu_addr[15]) begin
      if (!dec_ram) begin
        sel_c  = SEL_ROM;
        bank_c = dec_bank;
      end else if ({1'b0, dec_bank} < RAM_LIMIT_B) begin
        sel_c  = SEL_RAM;
        bank_c = dec_bank;
      end
    end else if (cpu_addr[15:13] == 3'b011) begin
      if ({1'b0, ram_base_q} < RAM_LIMIT_S) begin
        sel_c  = SEL_RAM;
        bank_c = BANK_W'(ram_base_q);
      end
    end
  end

  pbm_wgate u_wgate (
    .cpu_en   (cpu_en),
    .cpu_wr   (cpu_wr),
    .sel_i    (sel_c),
    .key_a_i  (key_a_q),
    .key_b_i  (key_b_q),
    .ram_we_o (ram_we)
  );

  assign map_sel    = sel_c;
  assign map_bank   = bank_c;
  assign map_offset = cpu_addr[12:0];

endmodule

// File: rtl/pbm_prg_mapper_chk.sv
module pbm_prg_mapper_chk
  import pbm_pkg::*;
#(
  parameter int BANK_W    = 7,
  parameter int RAM_SEL_W = 3,
  parameter int RAM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_en,
  input logic                 cpu_wr,
  input logic [15:0]          cpu_addr,
  input logic [1:0]           map_sel,
  input logic [BANK_W-1:0]    map_bank,
  input logic                 ram_we,
  input logic [1:0]           mode_q,
  input logic [7:0]           key_a_q,
  input logic [7:0]           key_b_q,
  input logic [RAM_SEL_W-1:0] ram_base_q
);

  p_we_needs_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (key_a_q == 8'h02 && key_b_q == 8'h01));

  p_we_needs_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (map_sel == SEL_RAM && cpu_en && cpu_wr));

  p_top_slot_rom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (map_sel == SEL_ROM));

  p_mode0_rom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && cpu_addr[15]) |-> (map_sel == SEL_ROM));

  p_window_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011 && map_sel == SEL_RAM)
      |-> (map_bank == BANK_W'(ram_base_q)));

  p_low_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> (map_sel == SEL_NONE && !ram_we));

  p_ram_backed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (map_sel == SEL_RAM) |-> (int'(map_bank) < RAM_BANKS));

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_en && cpu_wr) |=> $stable(mode_q));

endmodule

bind pbm_prg_mapper pbm_prg_mapper_chk #(
  .BANK_W    (BANK_W),
  .RAM_SEL_W (RAM_SEL_W),
  .RAM_BANKS (RAM_BANKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_en     (cpu_en),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .map_sel    (map_sel),
  .map_bank   (map_bank),
  .ram_we     (ram_we),
  .mode_q     (mode_q),
  .key_a_q    (key_a_q),
  .key_b_q    (key_b_q),
  .ram_base_q (ram_base_q)
);

// File: tb/sim_pbm_prg_mapper.sv
module sim_pbm_prg_mapper;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 64;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [1:0]  sel;
    logic [6:0]  bank;
    logic        we;
    logic [3:0]  req;
  } vec_t;

  // sel: 0 none, 1 ROM, 2 RAM. Register-write rows expect none/0/0.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h8000, 8'h00, 2'd1, 7'h7C, 1'b0, 4'd1},  // R1 reset banks
    '{1'b0, 16'hA123, 8'h00, 2'd1, 7'h7D, 1'b0, 4'd1},
    '{1'b0, 16'hC000, 8'h00, 2'd1, 7'h7E, 1'b0, 4'd1},
    '{1'b0, 16'hFFFF, 8'h00, 2'd1, 7'h7F, 1'b0, 4'd1},
    '{1'b0, 16'h6000, 8'h00, 2'd2, 7'h00, 1'b0, 4'd9},  // R9 base 0
    '{1'b1, 16'h6000, 8'h55, 2'd2, 7'h00, 1'b0, 4'd7},  // R7 locked
    '{1'b1, 16'h5102, 8'h02, 2'd0, 7'h00, 1'b0, 4'd11}, // R11 key A
    '{1'b1, 16'h5103, 8'h01, 2'd0, 7'h00, 1'b0, 4'd11}, // key B
    '{1'b1, 16'h6010, 8'hAA, 2'd2, 7'h00, 1'b1, 4'd7},  // R7 unlocked
    '{1'b1, 16'h8000, 8'hAA, 2'd1, 7'h7C, 1'b0, 4'd8},  // R8 ROM slot
    '{1'b1, 16'h5114, 8'h03, 2'd0, 7'h00, 1'b0, 4'd2},  // R2 reg0 RAM 3
    '{1'b0, 16'h8000, 8'h00, 2'd2, 7'h03, 1'b0, 4'd2},
    '{1'b1, 16'h9FFF, 8'h11, 2'd2, 7'h03, 1'b1, 4'd8},
    '{1'b1, 16'h5115, 8'h8A, 2'd0, 7'h00, 1'b0, 4'd2},  // reg1 ROM 0x0A
    '{1'b0, 16'hA000, 8'h00, 2'd1, 7'h0A, 1'b0, 4'd2},
    '{1'b1, 16'h5116, 8'h0E, 2'd0, 7'h00, 1'b0, 4'd6},  // R6 RAM 6 unbacked
    '{1'b1, 16'hC000, 8'h22, 2'd0, 7'h00, 1'b0, 4'd10}, // R10
    '{1'b1, 16'h5116, 8'h2A, 2'd0, 7'h00, 1'b0, 4'd6},  // RAM 0x2A -> 2
    '{1'b1, 16'hC0C5, 8'h33, 2'd2, 7'h02, 1'b1, 4'd6},
    '{1'b1, 16'h5117, 8'h15, 2'd0, 7'h00, 1'b0, 4'd2},  // reg3 bit7=0
    '{1'b0, 16'hE000, 8'h00, 2'd1, 7'h15, 1'b0, 4'd2},  // still ROM
    '{1'b1, 16'hE000, 8'h44, 2'd1, 7'h15, 1'b0, 4'd8},
    '{1'b1, 16'h5100, 8'h02, 2'd0, 7'h00, 1'b0, 4'd11}, // mode 2
    '{1'b0, 16'h8000, 8'h00, 2'd1, 7'h0A, 1'b0, 4'd5},  // R5
    '{1'b0, 16'hA000, 8'h00, 2'd1, 7'h0B, 1'b0, 4'd5},
    '{1'b0, 16'hC000, 8'h00, 2'd2, 7'h02, 1'b0, 4'd5},
    '{1'b0, 16'hE000, 8'h00, 2'd1, 7'h15, 1'b0, 4'd5},
    '{1'b1, 16'h5115, 8'h03, 2'd0, 7'h00, 1'b0, 4'd5},  // reg1 RAM
    '{1'b0, 16'h8000, 8'h00, 2'd2, 7'h02, 1'b0, 4'd5},
    '{1'b1, 16'hA000, 8'h66, 2'd2, 7'h03, 1'b1, 4'd5},
    '{1'b1, 16'h5100, 8'h01, 2'd0, 7'h00, 1'b0, 4'd11}, // mode 1
    '{1'b0, 16'h8000, 8'h00, 2'd2, 7'h02, 1'b0, 4'd4},  // R4
    '{1'b0, 16'hBFFF, 8'h00, 2'd2, 7'h03, 1'b0, 4'd4},
    '{1'b0, 16'hC000, 8'h00, 2'd1, 7'h14, 1'b0, 4'd4},
    '{1'b0, 16'hE000, 8'h00, 2'd1, 7'h15, 1'b0, 4'd4},
    '{1'b1, 16'hC000, 8'h77, 2'd1, 7'h14, 1'b0, 4'd8},
    '{1'b1, 16'h5115, 8'h85, 2'd0, 7'h00, 1'b0, 4'd4},  // reg1 ROM 0x05
    '{1'b0, 16'h8000, 8'h00, 2'd1, 7'h04, 1'b0, 4'd4},
    '{1'b0, 16'hA000, 8'h00, 2'd1, 7'h05, 1'b0, 4'd4},
    '{1'b1, 16'h5100, 8'h00, 2'd0, 7'h00, 1'b0, 4'd11}, // mode 0
    '{1'b0, 16'h8000, 8'h00, 2'd1, 7'h14, 1'b0, 4'd3},  // R3
    '{1'b0, 16'hA000, 8'h00, 2'd1, 7'h15, 1'b0, 4'd3},
    '{1'b0, 16'hC000, 8'h00, 2'd1, 7'h16, 1'b0, 4'd3},
    '{1'b0, 16'hE000, 8'h00, 2'd1, 7'h17, 1'b0, 4'd3},
    '{1'b1, 16'h8000, 8'h88, 2'd1, 7'h14, 1'b0, 4'd3},  // reg0 RAM ignored
    '{1'b1, 16'h5113, 8'h03, 2'd0, 7'h00, 1'b0, 4'd9},  // base 3
    '{1'b0, 16'h7FFF, 8'h00, 2'd2, 7'h03, 1'b0, 4'd9},
    '{1'b1, 16'h6000, 8'h99, 2'd2, 7'h03, 1'b1, 4'd9},
    '{1'b1, 16'h5113, 8'h05, 2'd0, 7'h00, 1'b0, 4'd10}, // base 5 unbacked
    '{1'b0, 16'h6000, 8'h00, 2'd0, 7'h00, 1'b0, 4'd10},
    '{1'b0, 16'h5FFF, 8'h00, 2'd0, 7'h00, 1'b0, 4'd10},
    '{1'b0, 16'h0000, 8'h00, 2'd0, 7'h00, 1'b0, 4'd10},
    '{1'b1, 16'h5103, 8'h02, 2'd0, 7'h00, 1'b0, 4'd7},  // wrong key B
    '{1'b1, 16'h5113, 8'h00, 2'd0, 7'h00, 1'b0, 4'd9},
    '{1'b1, 16'h6000, 8'h12, 2'd2, 7'h00, 1'b0, 4'd7},
    '{1'b1, 16'h5102, 8'h01, 2'd0, 7'h00, 1'b0, 4'd7},  // A=01 B=02
    '{1'b1, 16'h5103, 8'h01, 2'd0, 7'h00, 1'b0, 4'd7},  // A=01 B=01
    '{1'b1, 16'h6000, 8'h13, 2'd2, 7'h00, 1'b0, 4'd7},
    '{1'b1, 16'h5102, 8'h02, 2'd0, 7'h00, 1'b0, 4'd7},  // key right
    '{1'b1, 16'h6000, 8'h14, 2'd2, 7'h00, 1'b1, 4'd7},
    '{1'b1, 16'h5101, 8'h03, 2'd0, 7'h00, 1'b0, 4'd11}, // not a register
    '{1'b1, 16'h5118, 8'h83, 2'd0, 7'h00, 1'b0, 4'd11}, // not a register
    '{1'b0, 16'hA000, 8'h00, 2'd1, 7'h15, 1'b0, 4'd11}, // mode still 0
    '{1'b1, 16'h5100, 8'hFD, 2'd0, 7'h00, 1'b0, 4'd11}  // mode <- 1
  };

  logic        clk;
  logic        rst_n;
  logic        cpu_en;
  logic        cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [1:0]  map_sel;
  logic [6:0]  map_bank;
  logic [12:0] map_offset;
  logic        ram_we;

  int n_checks = 0;
  int n_fail   = 0;

  pbm_prg_mapper u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_en     (cpu_en),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .map_sel    (map_sel),
    .map_bank   (map_bank),
    .map_offset (map_offset),
    .ram_we     (ram_we)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [1:0] esel, input logic [6:0] ebank,
                       input logic ewe, input string req, input int idx);
    n_checks++;
    if (map_sel !== esel || map_bank !== ebank || ram_we !== ewe) begin
      n_fail++;
      $display("FAIL %s step %0d addr %h: sel/bank/we got %0d/%h/%0d expected %0d/%h/%0d",
               req, idx, cpu_addr, map_sel, map_bank, ram_we, esel, ebank, ewe);
    end
  endtask

  task automatic drive(input logic en, input logic wr,
                       input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_en    = en;
    cpu_wr    = wr;
    cpu_addr  = a;
    cpu_wdata = d;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cpu_en    = 1'b0;
    cpu_wr    = 1'b0;
    cpu_addr  = 16'h8000;
    cpu_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(2'd1, 7'h7C, 1'b0, "R1", -1);  // R1 in reset
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].data);
      check(VECS[i].sel, VECS[i].bank, VECS[i].we,
            $sformatf("R%0d", VECS[i].req), i);
    end

    // R11: mode now 1 (from data bits 1:0 of 0xFD): C000 -> {reg3[6:1],0}
    drive(1'b0, 1'b0, 16'hC000, 8'h00);
    check(2'd1, 7'h14, 1'b0, "R11", 100);
    // R11: write with cpu_en low is ignored
    drive(1'b0, 1'b1, 16'h5100, 8'h03);
    drive(1'b0, 1'b0, 16'hC000, 8'h00);
    check(2'd1, 7'h14, 1'b0, "R11", 101);
    // R8: no enable when cpu_en low, even on unlocked RAM
    drive(1'b0, 1'b1, 16'h6000, 8'h00);
    check(2'd2, 7'h00, 1'b0, "R8", 102);
    // R11/R6: mode 3; reg0 untouched by the 0x5118 write -> RAM 3
    drive(1'b1, 1'b1, 16'h5100, 8'h03);
    drive(1'b0, 1'b0, 16'h8000, 8'h00);
    check(2'd1 + 2'd1, 7'h03, 1'b0, "R11", 103);
    // R9: offset is address bits 12:0
    drive(1'b0, 1'b0, 16'h7ABC, 8'h00);
    n_checks++;
    if (map_offset !== 13'h1ABC) begin
      n_fail++;
      $display("FAIL R9 offset got %h expected %h", map_offset, 13'h1ABC);
    end

    // R1: reset in mid-run restores banks and clears the key
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    drive(1'b0, 1'b0, 16'h8000, 8'h00);
    check(2'd1, 7'h7C, 1'b0, "R1", 104);
    drive(1'b1, 1'b1, 16'h6000, 8'h00);
    check(2'd2, 7'h00, 1'b0, "R1", 105);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule